// File: doc/BRIEF.md
# Slow-Rate Current Predictor with Periodic Error Correction

This block sits on the boundary between a slow simulation step and a fast one. Each time a new slow-rate current sample arrives, it produces two corrected predictions. The first is for the next slow step and the second is for the step after that. Together they hide the one-step transport delay between the two rates.

The raw predictions come from a fixed three-tap linear extrapolator. The extrapolator runs over the newest sample and the two samples before it. The current being predicted is periodic, so the error from one step tends to come back one signal period later. For this reason the block keeps every step's prediction error in an on-chip delay line. It adds back the error stored a programmable number of steps earlier, where that number equals the period measured in slow steps.

One instance serves one converter side. The neighbouring logic gives each side its own delay length: the grid side uses the line frequency and the rotor side uses the slip frequency. The neighbouring logic also interpolates the two outputs down to the fast rate.

Top module: `pred3_comp`

## Requirements
- R1: While reset is high, and in the first cycle after a reset edge, out_valid is 0 and both prediction outputs are 0. The sample history and the error history also start from zero.
- R2: Samples and outputs are W-bit two's complement. The raw one-step prediction is the sum of x0, x0>>>2, x1>>>1, -(x2>>>1) and -(x2>>>2). Here x0 is the newest sample, x1 and x2 are the two samples before it, and >>> is an arithmetic shift that rounds toward minus infinity.
- R3: The raw two-step prediction uses the same taps with the corrected one-step output in the newest position. It is c1 + (c1>>>2) + (x0>>>1) - (x1>>>1) - (x1>>>2).
- R4: When a sample arrives, the block records one error: that sample minus the raw one-step prediction made at the previous sample, saturated to W bits. The previous raw prediction counts as 0 before the first sample.
- R5: Each output is its raw prediction plus the error recorded L samples earlier, where L is the effective delay length. The correction is zero while fewer than L earlier errors exist. The same correction is used for both outputs.
- R6: The effective delay length comes from delay_len. A value of 0 is used as 1, and a value above LAG_MAX is used as LAG_MAX.
- R7: A new delay_len applies from the sample presented with it onward. It does not clear the errors already stored.
- R8: Each raw prediction, each corrected output and each stored error is clamped to the range -2^(W-1) to 2^(W-1)-1.
- R9: A sample is taken at a rising edge with in_valid high. Both outputs update at the next rising edge, and out_valid is high for exactly the cycle after that edge. The outputs hold their values at all other times. Strobes must be at least two cycles apart.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | One-cycle strobe carrying a new slow-rate sample |
| in_sample | input | W | New current sample, signed |
| delay_len | input | $clog2(LAG_MAX+1) | Signal period in slow steps |
| out_valid | output | 1 | One-cycle pulse qualifying the outputs |
| out_pred1 | output | W | Corrected one-step-ahead prediction, signed |
| out_pred2 | output | W | Corrected two-step-ahead prediction, signed |

## Verification
A linear ramp checks the taps alone, because the extrapolator tracks a ramp exactly and leaves no error to correct. A pseudo-random sequence with a delay of one step separates the error bookkeeping from the taps. A triangle wave whose period matches the delay shows the correction reaching the outputs. A mid-stream change of delay, including the zero and above-maximum values, shows that stored errors survive and that the length is clamped. Alternating full-scale extremes drive every sum into saturation, while a spacing check on each pulse and a hold check between pulses cover the handshake.

// File: rtl/pred3_pkg.sv
package pred3_pkg;

    localparam int unsigned DATA_W_DEF  = 16;
    localparam int unsigned LAG_MAX_DEF = 1024;

    typedef logic signed [63:0] wide_t;

    // Clamp a wide signed value into the range of a w-bit signed number.
    function automatic wide_t clamp_w(input wide_t v, input int unsigned w);
        wide_t hi;
        wide_t lo;
        hi = (64'sd1 <<< (w - 1)) - 64'sd1;
        lo = -(64'sd1 <<< (w - 1));
        if (v > hi)      return hi;
        else if (v < lo) return lo;
        else             return v;
    endfunction

    // Three-tap extrapolator: 5/4 a + 1/2 b - 3/4 c, realised as shifts and adds.
    function automatic wide_t tap3(input wide_t a, input wide_t b, input wide_t c);
        return a + (a >>> 2) + (b >>> 1) - (c >>> 1) - (c >>> 2);
    endfunction

endpackage

// File: rtl/pred3_taps.sv
module pred3_taps
    import pred3_pkg::*;
#(
    parameter int unsigned W  = DATA_W_DEF,
    parameter int unsigned WI = W + 4
) (
    input  logic signed [W-1:0]  newest,
    input  logic signed [W-1:0]  mid,
    input  logic signed [W-1:0]  oldest,
    output logic signed [WI-1:0] sum
);
    wide_t full;

    always_comb begin
        full = tap3(wide_t'(newest), wide_t'(mid), wide_t'(oldest));
        sum  = full[WI-1:0];
    end

endmodule

// File: rtl/pred3_err_line.sv
module pred3_err_line
    import pred3_pkg::*;
#(
    parameter int unsigned W       = DATA_W_DEF,
    parameter int unsigned LAG_MAX = LAG_MAX_DEF,
    localparam int unsigned LW     = $clog2(LAG_MAX + 1)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                push,
    input  logic signed [W-1:0] err_in,
    input  logic [LW-1:0]       lag_in,
    output logic signed [W-1:0] corr_out
);
    localparam int unsigned AW    = (LAG_MAX > 1) ? $clog2(LAG_MAX) : 1;
    localparam int unsigned DEPTH = 1 << AW;

    logic signed [W-1:0] mem [DEPTH];
    logic [AW-1:0]       wr_ptr;
    logic [AW-1:0]       rd_addr;
    logic [LW-1:0]       lag_eff;
    logic [LW-1:0]       fill;
    logic signed [W-1:0] rd_q;
    logic                aged;

    always_comb begin
        if (lag_in == '0)                lag_eff = LW'(1);
        else if (lag_in > LW'(LAG_MAX))  lag_eff = LW'(LAG_MAX);
        else                             lag_eff = lag_in;
        rd_addr = wr_ptr - lag_eff[AW-1:0];
    end

    // Storage has no reset; the fill count masks entries not yet written.
    always_ff @(posedge clk) begin
        if (push) mem[wr_ptr] <= err_in;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            fill   <= '0;
            rd_q   <= '0;
            aged   <= 1'b0;
        end else if (push) begin
            wr_ptr <= wr_ptr + AW'(1);
            if (fill != LW'(LAG_MAX)) fill <= fill + LW'(1);
            rd_q   <= mem[rd_addr];
            aged   <= (fill >= lag_eff);
        end
    end

    assign corr_out = aged ? rd_q : '0;

    // R5: no correction until the line holds at least the effective length
    assert_young_zero_R5: assert property (@(posedge clk) disable iff (rst)
        (push && (fill < lag_eff)) |=> (corr_out == '0))
        else $error("correction used before enough errors were stored");

endmodule

// File: rtl/pred3_comp.sv
module pred3_comp
    import pred3_pkg::*;
#(
    parameter int unsigned W       = DATA_W_DEF,
    parameter int unsigned LAG_MAX = LAG_MAX_DEF,
    localparam int unsigned LW     = $clog2(LAG_MAX + 1)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                in_valid,
    input  logic signed [W-1:0] in_sample,
    input  logic [LW-1:0]       delay_len,
    output logic                out_valid,
    output logic signed [W-1:0] out_pred1,
    output logic signed [W-1:0] out_pred2
);
    localparam int unsigned WI = W + 4;

    logic signed [W-1:0]  x0, x1, x2;
    logic signed [W-1:0]  prev_raw;
    logic                 fire;
    logic signed [W-1:0]  err_now;
    logic signed [W-1:0]  corr;
    logic signed [WI-1:0] t1, t2;
    logic signed [W-1:0]  raw1, cor1, cor2;
    wide_t                e_w, r1_w, c1_w, c2_w;

    // Error of the previous raw one-step prediction against the new sample.
    always_comb begin
        e_w     = clamp_w(wide_t'(in_sample) - wide_t'(prev_raw), W);
        err_now = e_w[W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            x0   <= '0;
            x1   <= '0;
            x2   <= '0;
            fire <= 1'b0;
        end else begin
            fire <= in_valid;
            if (in_valid) begin
                x0 <= in_sample;
                x1 <= x0;
                x2 <= x1;
            end
        end
    end

    pred3_err_line #(.W(W), .LAG_MAX(LAG_MAX)) u_err (
        .clk      (clk),
        .rst      (rst),
        .push     (in_valid),
        .err_in   (err_now),
        .lag_in   (delay_len),
        .corr_out (corr)
    );

    pred3_taps #(.W(W), .WI(WI)) u_tap_one (
        .newest (x0),
        .mid    (x1),
        .oldest (x2),
        .sum    (t1)
    );

    always_comb begin
        r1_w = clamp_w(wide_t'(t1), W);
        c1_w = clamp_w(wide_t'(t1) + wide_t'(corr), W);
        raw1 = r1_w[W-1:0];
        cor1 = c1_w[W-1:0];
    end

    pred3_taps #(.W(W), .WI(WI)) u_tap_two (
        .newest (cor1),
        .mid    (x0),
        .oldest (x1),
        .sum    (t2)
    );

    always_comb begin
        c2_w = clamp_w(wide_t'(t2) + wide_t'(corr), W);
        cor2 = c2_w[W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_pred1 <= '0;
            out_pred2 <= '0;
            prev_raw  <= '0;
        end else begin
            out_valid <= fire;
            if (fire) begin
                out_pred1 <= cor1;
                out_pred2 <= cor2;
                prev_raw  <= raw1;
            end
        end
    end

    // R1: outputs cleared by reset
    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (!out_valid && out_pred1 == '0 && out_pred2 == '0))
        else $error("outputs not cleared by reset");

    // R9: a sample yields a pulse two edges later
    assert_valid_after_strobe_R9: assert property (@(posedge clk) disable iff (rst)
        in_valid |-> ##2 out_valid)
        else $error("missing output pulse");

    // R9: pulse lasts one cycle
    assert_single_pulse_R9: assert property (@(posedge clk) disable iff (rst)
        out_valid |=> !out_valid)
        else $error("output pulse longer than one cycle");

    // R9: outputs hold between pulses
    assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> ($stable(out_pred1) && $stable(out_pred2)))
        else $error("outputs changed without a pulse");

    // R9: strobe spacing rule
    assert_strobe_gap_R9: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> !in_valid)
        else $error("strobes closer than two cycles");

endmodule

// File: tb/pred3_comp_tb.sv
`timescale 1ns/1ps
module pred3_comp_tb;
    localparam int W       = 16;
    localparam int LAG_MAX = 16;
    localparam int LW      = $clog2(LAG_MAX + 1);

    logic                clk = 1'b0;
    logic                rst = 1'b1;
    logic                in_valid = 1'b0;
    logic signed [W-1:0] in_sample = '0;
    logic [LW-1:0]       delay_len = '0;
    logic                out_valid;
    logic signed [W-1:0] out_pred1, out_pred2;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done = 1'b0;

    longint exp1_q[$];
    longint exp2_q[$];
    int     cyc_q[$];
    string  tag_q[$];

    longint mx1 = 0, mx2 = 0, mprev = 0;
    longint merr[$];
    longint last1 = 0, last2 = 0;
    int     lcg = 12345;

    pred3_comp #(.W(W), .LAG_MAX(LAG_MAX)) u_dut (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_sample (in_sample),
        .delay_len (delay_len),
        .out_valid (out_valid),
        .out_pred1 (out_pred1),
        .out_pred2 (out_pred2)
    );

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic longint sat(input longint v);
        if (v > 32767)  return 32767;
        if (v < -32768) return -32768;
        return v;
    endfunction

    function automatic longint taps(input longint a, input longint b, input longint c);
        return a + (a >>> 2) + (b >>> 1) - (c >>> 1) - (c >>> 2);
    endfunction

    task automatic check(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Driver: computes the expected outputs and pushes them to the scoreboard.
    task automatic send(input longint x, input int lam, input string tag);
        longint e, corr, w1, raw1, c1, w2, c2;
        int k, le;
        le = (lam == 0) ? 1 : ((lam > LAG_MAX) ? LAG_MAX : lam);
        k  = merr.size();
        e  = sat(x - mprev);
        corr = (k >= le) ? merr[k - le] : 0;
        merr.push_back(e);
        w1   = taps(x, mx1, mx2);
        raw1 = sat(w1);
        c1   = sat(w1 + corr);
        w2   = taps(c1, x, mx1);
        c2   = sat(w2 + corr);
        mprev = raw1;
        mx2 = mx1;
        mx1 = x;
        @(negedge clk);
        in_valid  = 1'b1;
        in_sample = W'(x);
        delay_len = LW'(lam);
        exp1_q.push_back(c1);
        exp2_q.push_back(c2);
        cyc_q.push_back(cyc + 2);
        tag_q.push_back(tag);
        @(negedge clk);
        in_valid = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    // Monitor: pops expected items as pulses appear, checks hold in between.
    always @(negedge clk) begin
        if (!rst && !done) begin
            if (out_valid) begin
                if (exp1_q.size() == 0) begin
                    checks++;
                    errors++;
                    $display("FAIL R9: actual unexpected pulse expected none");
                end else begin
                    string t;
                    t = tag_q.pop_front();
                    check(t, longint'(out_pred1), exp1_q.pop_front());
                    check({"R3/", t}, longint'(out_pred2), exp2_q.pop_front());
                    check("R9 latency", cyc, cyc_q.pop_front());
                    last1 = longint'(out_pred1);
                    last2 = longint'(out_pred2);
                end
            end else begin
                check("R9 hold p1", longint'(out_pred1), last1);
                check("R9 hold p2", longint'(out_pred2), last2);
            end
        end
    end

    function automatic longint tri6(input int k);
        case (k % 6)
            0: return 0;
            1: return 3000;
            2: return 6000;
            3: return 3000;
            4: return 0;
            default: return -3000;
        endcase
    endfunction

    initial begin
        repeat (4) @(negedge clk);
        // R1: reset state held while reset is high
        check("R1 valid", longint'(out_valid), 0);
        check("R1 p1", longint'(out_pred1), 0);
        check("R1 p2", longint'(out_pred2), 0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 after release", longint'(out_pred1) + longint'(out_pred2) + longint'(out_valid), 0);

        // R2: ramp, taps alone track it exactly
        for (int k = 0; k < 10; k++) send(100 * k, 4, "R2");
        // R4: pseudo-random values with delay of one step
        for (int k = 0; k < 8; k++) begin
            lcg = lcg * 1103515245 + 12345;
            send(longint'((lcg >>> 16) % 4000), 1, "R4");
        end
        // R5: triangle whose period equals the delay
        for (int k = 0; k < 24; k++) send(tri6(k), 6, "R5");
        // R7: change delay mid-stream, stored errors retained
        for (int k = 0; k < 8; k++) send(tri6(k) + 500, 3, "R7");
        // R6: zero length used as one, oversize length clamped
        for (int k = 0; k < 6; k++) send(tri6(k) - 700, 0, "R6");
        for (int k = 0; k < 20; k++) send(tri6(k) * 2, 31, "R6");
        // R8: full-scale extremes saturate sums
        for (int k = 0; k < 8; k++) send((k % 2 == 0) ? 32767 : -32768, 2, "R8");
        for (int k = 0; k < 4; k++) send(32767, 16, "R8");

        repeat (6) @(negedge clk);
        check("R9 queue drained", exp1_q.size(), 0);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL R9 watchdog: actual not finished expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule